// File: doc/BRIEF.md
# Packet Crossbar Destination Port

This block is the receiving end of a crossbar for a single core. A set of cache-bank sources competes for this one destination. Each source sends 145-bit packets. A source announces a packet by raising its request line. From the next cycle on it drives the packet and holds it until it sees its grant.

The port registers the requests. A round-robin arbiter picks one pending source per cycle, and the arbiter returns a one-cycle grant. In the grant cycle the port takes the winner's packet into a capture register. One pipeline cycle later the port presents the packet to the core. The core side has no grant and no stall. The port drives a request strobe in the same cycle as the packet, and the top bit of the packet is the valid flag. The core accepts a packet by that flag alone. When no packet is being sent, the strobe, the flag and the payload are all zero, so the core never sees a packet twice.

Top module: `xbar_dest_port`

## Requirements
- R1: After reset every grant, the core strobe and every bit of the core packet are 0, and the arbitration pointer starts at source 0. The first contest among all sources therefore goes to source 0.
- R2: A grant is one-hot or zero and lasts one cycle. It goes only to a source whose request was sampled two edges earlier. At the earliest it is visible in the second cycle after the request is first sampled, which is the third cycle of the transfer.
- R3: Arbitration is round-robin. The search starts at the source after the most recently granted one and wraps from the highest index to 0.
- R4: A source that loses keeps its request and is granted in a later cycle. No requesting source is passed over while the other sources take more than one turn each.
- R5: The payload bits 143:0 that the granted source drives in its grant cycle reach the core unchanged. They appear exactly two cycles after the grant cycle: one capture cycle plus one ready delay.
- R6: The core strobe and packet bit 144 are both 1 for exactly one cycle per forwarded packet. In every cycle without a packet the whole 145-bit core packet is 0.
- R7: Bit 144 of a source packet is ignored and the port sets it itself. Packets from sources that are not requesting never reach the core.
- R8: Different sources can be granted in consecutive cycles. Their packets then reach the core in consecutive cycles with no gap.
- R9: A request held in the cycle after a grant counts as a new packet. The same source is granted again no sooner than three cycles after its previous grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | N_SRC | Request per source, held until granted |
| src_pkt_i | input | N_SRC x PKT_W | Packet per source, bit VALID_BIT ignored |
| src_gnt_o | output | N_SRC | One-cycle grant per source |
| core_req_o | output | 1 | Strobe to the core, same cycle as the packet |
| core_pkt_o | output | PKT_W | Packet to the core, valid flag at VALID_BIT, zero when idle |

## Verification
A stale request mask inside the port would show at the ports as a second grant to the same source one or two cycles after its first grant, and the core would then receive a duplicate packet two cycles later. A wrong pointer shows in the first contested cycle, as the wrong grant order and the wrong packet order at the core. A fault in the capture or delay stages shows as a wrong or held payload, or a strobe that arrives one cycle early or late, two cycles after the grant.

// File: rtl/xdp_pkg.sv
`timescale 1ns/1ps
package xdp_pkg;
   localparam int unsigned XDP_MAX_SRC   = 32;
   localparam int unsigned XDP_MAX_DELAY = 4;

   function automatic int unsigned xdp_ptr_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/xdp_req_track.sv
`timescale 1ns/1ps
module xdp_req_track #(
   parameter int unsigned N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req_i,
   input  logic [N_SRC-1:0] gnt_now_i,
   output logic [N_SRC-1:0] pend_o
);
   logic [N_SRC-1:0] req_q;
   logic [N_SRC-1:0] gnt_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= '0;
         gnt_last_q <= '0;
      end else begin
         req_q      <= req_i;
         gnt_last_q <= gnt_now_i;
      end
   end

   // The request sampled in the grant cycle and in the cycle after it
   // still belongs to the packet just granted.
   assign pend_o = req_q & ~gnt_now_i & ~gnt_last_q;
endmodule

// File: rtl/xdp_rr_arb.sv
`timescale 1ns/1ps
module xdp_rr_arb #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned PTR_W = xdp_pkg::xdp_ptr_w(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] pend_i,
   output logic [N_SRC-1:0] gnt_o
);
   localparam logic [PTR_W:0]   N_EXT = (PTR_W+1)'(N_SRC);
   localparam logic [PTR_W-1:0] LAST  = PTR_W'(N_SRC - 1);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] win_idx;
   logic             win_found;
   logic [N_SRC-1:0] gnt_q;

   always_comb begin
      win_found = 1'b0;
      win_idx   = '0;
      for (int i = 0; i < N_SRC; i++) begin
         logic [PTR_W:0]   sum;
         logic [PTR_W-1:0] cand;
         sum = {1'b0, ptr_q} + (PTR_W+1)'(i);
         if (sum >= N_EXT) sum = sum - N_EXT;
         cand = sum[PTR_W-1:0];
         if (!win_found && pend_i[cand]) begin
            win_found = 1'b1;
            win_idx   = cand;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         gnt_q <= '0;
      end else begin
         gnt_q <= win_found ? (N_SRC'(1) << win_idx) : '0;
         if (win_found) ptr_q <= (win_idx == LAST) ? '0 : win_idx + PTR_W'(1);
      end
   end

   assign gnt_o = gnt_q;
endmodule

// File: rtl/xdp_capture.sv
`timescale 1ns/1ps
module xdp_capture #(
   parameter int unsigned N_SRC     = 4,
   parameter int unsigned PKT_W     = 145,
   parameter int unsigned VALID_BIT = PKT_W - 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_SRC-1:0]            gnt_i,
   input  logic [N_SRC-1:0][PKT_W-1:0] pkt_i,
   output logic                        vld_o,
   output logic [PKT_W-1:0]            pkt_o
);
   localparam logic [PKT_W-1:0] VB_MASK = PKT_W'(1) << VALID_BIT;

   logic [PKT_W-1:0] sel;
   logic             any;
   logic             vld_q;
   logic [PKT_W-1:0] pkt_q;

   always_comb begin
      sel = '0;
      for (int s = 0; s < N_SRC; s++) begin
         sel = sel | (pkt_i[s] & {PKT_W{gnt_i[s]}});
      end
   end

   assign any = |gnt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         pkt_q <= '0;
      end else begin
         vld_q <= any;
         pkt_q <= any ? (sel | VB_MASK) : '0;
      end
   end

   assign vld_o = vld_q;
   assign pkt_o = pkt_q;
endmodule

// File: rtl/xdp_out_pipe.sv
`timescale 1ns/1ps
module xdp_out_pipe #(
   parameter int unsigned PKT_W = 145,
   parameter int unsigned DELAY = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [PKT_W-1:0] pkt_i,
   output logic             vld_o,
   output logic [PKT_W-1:0] pkt_o
);
   if (DELAY == 0) begin : g_pass
      assign vld_o = vld_i;
      assign pkt_o = pkt_i;
   end else begin : g_stages
      logic [DELAY-1:0]            vld_q;
      logic [DELAY-1:0][PKT_W-1:0] pkt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[0] <= 1'b0;
            pkt_q[0] <= '0;
         end else begin
            vld_q[0] <= vld_i;
            pkt_q[0] <= pkt_i;
         end
      end

      for (genvar k = 1; k < DELAY; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[k] <= 1'b0;
               pkt_q[k] <= '0;
            end else begin
               vld_q[k] <= vld_q[k-1];
               pkt_q[k] <= pkt_q[k-1];
            end
         end
      end

      assign vld_o = vld_q[DELAY-1];
      assign pkt_o = pkt_q[DELAY-1];
   end
endmodule

// File: rtl/xbar_dest_port.sv
`timescale 1ns/1ps
module xbar_dest_port #(
   parameter int unsigned N_SRC     = 4,
   parameter int unsigned PKT_W     = 145,
   parameter int unsigned VALID_BIT = PKT_W - 1,
   parameter int unsigned OUT_DELAY = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_SRC-1:0]            src_req_i,
   input  logic [N_SRC-1:0][PKT_W-1:0] src_pkt_i,
   output logic [N_SRC-1:0]            src_gnt_o,
   output logic                        core_req_o,
   output logic [PKT_W-1:0]            core_pkt_o
);
   if (N_SRC < 2 || N_SRC > xdp_pkg::XDP_MAX_SRC) begin : g_bad_nsrc
      $error("xbar_dest_port: N_SRC out of range");
   end
   if (VALID_BIT >= PKT_W || PKT_W < 2) begin : g_bad_vbit
      $error("xbar_dest_port: VALID_BIT must lie inside the packet");
   end
   if (OUT_DELAY > xdp_pkg::XDP_MAX_DELAY) begin : g_bad_delay
      $error("xbar_dest_port: OUT_DELAY too large");
   end

   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] gnt;
   logic             cap_vld;
   logic [PKT_W-1:0] cap_pkt;

   xdp_req_track #(.N_SRC(N_SRC)) track_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (src_req_i),
      .gnt_now_i (gnt),
      .pend_o    (pend)
   );

   xdp_rr_arb #(.N_SRC(N_SRC)) arb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .gnt_o  (gnt)
   );

   xdp_capture #(.N_SRC(N_SRC), .PKT_W(PKT_W), .VALID_BIT(VALID_BIT)) cap_i (
      .clk   (clk),
      .rst_n (rst_n),
      .gnt_i (gnt),
      .pkt_i (src_pkt_i),
      .vld_o (cap_vld),
      .pkt_o (cap_pkt)
   );

   xdp_out_pipe #(.PKT_W(PKT_W), .DELAY(OUT_DELAY)) pipe_i (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (cap_vld),
      .pkt_i (cap_pkt),
      .vld_o (core_req_o),
      .pkt_o (core_pkt_o)
   );

   assign src_gnt_o = gnt;
endmodule

// File: rtl/xdp_port_chk.sv
`timescale 1ns/1ps
module xdp_port_chk #(
   parameter int unsigned N_SRC     = 4,
   parameter int unsigned PKT_W     = 145,
   parameter int unsigned VALID_BIT = PKT_W - 1,
   parameter int unsigned OUT_DELAY = 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [N_SRC-1:0]            src_req_i,
   input logic [N_SRC-1:0]            src_gnt_o,
   input logic                        core_req_o,
   input logic [PKT_W-1:0]            core_pkt_o
);
   a_r2_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_gnt_o));

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      a_r2_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
         src_gnt_o[s] |-> $past(src_req_i[s], 2));
      a_r2_gnt_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         src_gnt_o[s] |=> !src_gnt_o[s]);
      a_r9_no_regrant_gap2: assert property (@(posedge clk) disable iff (!rst_n)
         src_gnt_o[s] |-> ##2 !src_gnt_o[s]);
   end

   a_r5_out_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      core_req_o |-> $past(|src_gnt_o, OUT_DELAY + 1));
   a_r5_gnt_reaches_out: assert property (@(posedge clk) disable iff (!rst_n)
      $past(|src_gnt_o, OUT_DELAY + 1) |-> core_req_o);
   a_r6_valid_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      core_req_o |-> core_pkt_o[VALID_BIT]);
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !core_req_o |-> (core_pkt_o == '0));
endmodule

bind xbar_dest_port xdp_port_chk #(
   .N_SRC(N_SRC), .PKT_W(PKT_W), .VALID_BIT(VALID_BIT), .OUT_DELAY(OUT_DELAY)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_req_i  (src_req_i),
   .src_gnt_o  (src_gnt_o),
   .core_req_o (core_req_o),
   .core_pkt_o (core_pkt_o)
);

// File: tb/xbar_dest_port_tb_top.sv
`timescale 1ns/1ps
module xbar_dest_port_tb_top;
   localparam int N = 4;
   localparam int W = 145;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      src_req = '0;
   logic [N-1:0][W-1:0] src_pkt = '0;
   logic [N-1:0]      src_gnt;
   logic              core_req;
   logic [W-1:0]      core_pkt;

   always #5 clk = ~clk;

   xbar_dest_port #(.N_SRC(N), .PKT_W(W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_req_i  (src_req),
      .src_pkt_i  (src_pkt),
      .src_gnt_o  (src_gnt),
      .core_req_o (core_req),
      .core_pkt_o (core_pkt)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int ng = 0, no = 0, perr = 0;
   int gcyc [32];
   int gsrc [32];
   int ocyc [32];
   logic [W-1:0] opkt [32];
   int left [N];
   int seqn [N];
   bit gseen [N];

   task automatic chk(input bit ok, input string tag, input logic [159:0] act, input logic [159:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] mk(input int s, input int q);
      logic [15:0] w;
      w = 16'h5A00 + 16'(s * 256) + 16'(q);
      return {1'b0, {9{w}}};
   endfunction

   function automatic logic [W-1:0] withv(input logic [W-1:0] p);
      logic [W-1:0] r;
      r = p;
      r[W-1] = 1'b1;
      return r;
   endfunction

   task automatic step();
      @(negedge clk);
      cyc++;
      for (int s = 0; s < N; s++) begin
         if (src_gnt[s] && ng < 32) begin
            gcyc[ng] = cyc; gsrc[ng] = s; ng++;
         end
      end
      if (core_req) begin
         if (no < 32) begin ocyc[no] = cyc; opkt[no] = core_pkt; no++; end
         if (!core_pkt[W-1]) perr++;
      end else if (core_pkt != '0) perr++;
      for (int s = 0; s < N; s++) begin
         if (gseen[s]) begin
            left[s]--; seqn[s]++;
            if (left[s] > 0) src_pkt[s] = mk(s, seqn[s]);
            else src_req[s] = 1'b0;
         end
         gseen[s] = src_gnt[s];
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic launch(input int s, input int n, input bit vbit);
      left[s] = n; seqn[s] = 0;
      src_pkt[s] = mk(s, 0);
      src_pkt[s][W-1] = vbit;
      src_req[s] = 1'b1;
   endtask

   task automatic clear_log();
      ng = 0; no = 0; perr = 0;
   endtask

   task automatic chk_gnt(input int i, input int s, input int c, input string tag);
      chk(ng > i && gsrc[i] == s, {tag, " grant source"}, 160'(gsrc[i]), 160'(s));
      chk(ng > i && gcyc[i] == c, {tag, " grant cycle"}, 160'(gcyc[i]), 160'(c));
   endtask

   task automatic chk_out(input int i, input logic [W-1:0] p, input int c, input string tag);
      chk(no > i && ocyc[i] == c, {tag, " core cycle"}, 160'(ocyc[i]), 160'(c));
      chk(no > i && opkt[i] == withv(p), {tag, " core packet"}, 160'(opkt[i]), 160'(withv(p)));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      run(3);
      chk(src_gnt == '0, "R1 grants in reset", 160'(src_gnt), 160'(0));
      chk(core_req == 1'b0, "R1 strobe in reset", 160'(core_req), 160'(0));
      chk(core_pkt == '0, "R1 packet in reset", 160'(core_pkt), 160'(0));
      rst_n = 1'b1;
      run(2);
      chk(core_req == 1'b0 && src_gnt == '0, "R1 idle after reset", 160'({src_gnt, core_req}), 160'(0));
   endtask

   task automatic t_all_four();
      int k;
      clear_log(); k = cyc;
      for (int s = 0; s < N; s++) launch(s, 1, 1'b0);
      run(12);
      chk(ng == 4, "R8 grant count", 160'(ng), 160'(4));
      for (int s = 0; s < N; s++) chk_gnt(s, s, k + 2 + s, "R1 R3 R8 all four");
      chk(no == 4, "R8 core count", 160'(no), 160'(4));
      for (int s = 0; s < N; s++) chk_out(s, mk(s, 0), k + 4 + s, "R5 R8 all four");
      chk(perr == 0, "R6 strobe and flag", 160'(perr), 160'(0));
   endtask

   task automatic t_single();
      int k;
      clear_log(); k = cyc;
      launch(2, 1, 1'b1);
      run(10);
      chk(ng == 1, "R2 single grant count", 160'(ng), 160'(1));
      chk_gnt(0, 2, k + 2, "R2 single");
      chk(no == 1, "R6 single core count", 160'(no), 160'(1));
      chk_out(0, mk(2, 0), k + 4, "R5 R7 single");
      chk(perr == 0, "R6 single no hold", 160'(perr), 160'(0));
   endtask

   task automatic t_round_robin();
      int k;
      clear_log(); k = cyc;
      launch(1, 1, 1'b0);
      run(8);
      chk_gnt(0, 1, k + 2, "R3 lone source");
      clear_log(); k = cyc;
      launch(0, 1, 1'b0);
      launch(3, 1, 1'b0);
      run(10);
      chk(ng == 2, "R4 contest grants", 160'(ng), 160'(2));
      chk_gnt(0, 3, k + 2, "R3 pointer after source 1");
      chk_gnt(1, 0, k + 3, "R4 loser granted later");
      chk_out(0, mk(3, 0), k + 4, "R5 contest first");
      chk_out(1, mk(0, 0), k + 5, "R5 contest second");
   endtask

   task automatic t_rerequest();
      int k;
      clear_log(); k = cyc;
      launch(0, 2, 1'b0);
      launch(1, 2, 1'b0);
      run(14);
      chk(ng == 4, "R9 grant count", 160'(ng), 160'(4));
      chk_gnt(0, 1, k + 2, "R9 first");
      chk_gnt(1, 0, k + 3, "R4 R9 second");
      chk_gnt(2, 1, k + 5, "R9 regrant gap");
      chk_gnt(3, 0, k + 6, "R9 regrant other");
      chk(no == 4, "R9 core count", 160'(no), 160'(4));
      chk_out(0, mk(1, 0), k + 4, "R9 out0");
      chk_out(1, mk(0, 0), k + 5, "R9 out1");
      chk_out(2, mk(1, 1), k + 7, "R9 out2");
      chk_out(3, mk(0, 1), k + 8, "R9 out3");
      chk(perr == 0, "R6 rerequest no hold", 160'(perr), 160'(0));
   endtask

   task automatic t_ignore();
      clear_log();
      for (int s = 0; s < N; s++) begin
         src_pkt[s] = withv(mk(s, 7));
         src_req[s] = 1'b0;
      end
      run(10);
      chk(ng == 0, "R7 no grant without request", 160'(ng), 160'(0));
      chk(no == 0, "R7 no packet without request", 160'(no), 160'(0));
      chk(perr == 0 && core_pkt == '0, "R7 R6 core stays zero", 160'(core_pkt), 160'(0));
   endtask

   initial begin
      for (int s = 0; s < N; s++) begin left[s] = 0; seqn[s] = 0; gseen[s] = 1'b0; end
      t_reset();
      t_all_four();
      t_single();
      t_round_robin();
      t_rerequest();
      t_ignore();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule